// File: doc/BRIEF.md
# Interrupt Request Vectoring Controller

This block gathers pending requests from thirteen interrupt sources and decides, at each instruction boundary, whether a simple instruction sequencer should divert to a handler and at which address. Every source has a pending flag and an enable bit. A flag can be set by a one-cycle pulse from its peripheral, or by a software write to the pending register. The flag leads to a vector only when its enable bit, the global enable and an idle in-service state all allow it. Among the flags that qualify, the lowest source index wins. The handler address is 0x0003 plus eight times that index.

The sequencer marks the last cycle of each instruction with a boundary strobe. With that strobe it states whether the instruction that follows is single-cycle or multi-cycle. Clearing the global enable does not act on the boundary that ends the clearing instruction when the next instruction is single-cycle. A vector may still be issued there, and the global enable already reads 0 inside the handler. When the next instruction is multi-cycle, the disable acts on that boundary. A return strobe ends the in-service state. A qualifying flag that is still set causes a new vector at the boundary after the one on which the return completed.

A fixed per-source mask, set by a parameter and applied from reset, selects the sources whose flag is cleared by hardware at the moment of vectoring. Those sources also receive a one-cycle acknowledge pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, all pending flags, all enable bits, the global enable and the in-service state are 0, and `vec_req_o` and `ack_o` are 0.
- R2: A high bit of `src_set_i` sets the matching bit of `flag_o` one cycle later. A pending-register write loads `flag_wdata_i` into `flag_o`, so a 1 sets a flag and a 0 clears it. A set pulse in the same cycle as a write of 0 leaves that flag set.
- R3: A vector is decided only in a cycle where `bnd_i` is high. `vec_req_o` then goes high for exactly one cycle, in the cycle after that boundary. With no boundary, a pending enabled flag produces no vector.
- R4: When several enabled flags are pending, the lowest index is served. `vec_addr_o` equals 16'h0003 + 8 × index.
- R5: A flag set by a software write vectors exactly like one set by its peripheral.
- R6: With the default mask, sources 0, 2, 4 and 6 are auto-cleared. Vectoring to one of them clears its flag and pulses its bit of `ack_o` together with `vec_req_o`. Vectoring to any other source leaves its flag set, and `ack_o` stays 0.
- R7: After a vector, no further vector is issued until `reti_i` has been seen. A boundary in the same cycle as `reti_i` issues no vector. The next boundary does vector if a qualifying flag is still set.
- R8: After the global enable is written to 0, `gie_o` reads 0 from the next cycle. At the first boundary after that write, a qualifying flag vectors if `bnd_next_multi_i` is 0 and does not vector if it is 1.
- R9: Past that first boundary, no vector is issued while the global enable is 0.
- R10: A pending flag whose enable bit is 0 never causes a vector and stays readable in `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | 13 | Per-source set pulses from peripherals |
| flag_wr_i | input | 1 | Write strobe for the pending register |
| flag_wdata_i | input | 13 | Value written to the pending register |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 13 | Value written to the enable register |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| bnd_i | input | 1 | Last cycle of an instruction |
| bnd_next_multi_i | input | 1 | With `bnd_i`: the next instruction is multi-cycle |
| reti_i | input | 1 | Return-from-handler completed |
| vec_req_o | output | 1 | One-cycle vector request |
| vec_addr_o | output | 16 | Handler address, valid with `vec_req_o` |
| ack_o | output | 13 | One-hot acknowledge for an auto-cleared source |
| flag_o | output | 13 | Pending register |
| en_o | output | 13 | Enable register |
| gie_o | output | 1 | Global enable |

## Verification
Two coincidences matter most. The first is a boundary in the cycle of the return strobe, which must not vector even though a flag is waiting. The second is a global-enable clear whose first boundary carries the single-cycle or multi-cycle indication. The bench drives the return strobe and the boundary together and expects no request, then expects the request at the very next boundary. It clears the global enable, posts a flag and issues the boundary under each instruction-length indication. It then judges both the request and the global enable read back in the cycle after the boundary. A further case is a peripheral set pulse that lands in the same cycle as a software write of 0, where the pulse must win.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC_DEF     = 13;
  localparam int unsigned ADDR_W_DEF    = 16;
  localparam int unsigned VEC_BASE_DEF  = 3;
  localparam int unsigned STRIDE_LG_DEF = 3;
  localparam logic [N_SRC_DEF-1:0] AUTO_MASK_DEF = 13'b0_0000_0101_0101;

  typedef enum logic [1:0] {
    GATE_SHUT = 2'd0,
    GATE_OPEN = 2'd1,
    GATE_LAG  = 2'd2
  } gate_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 13,
  parameter logic [N-1:0] AUTO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic         fire_i,
  input  logic [N-1:0] grant_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] ready_o
);
  logic [N-1:0] flag_q, en_q, flag_d, hw_clr;

  assign hw_clr = fire_i ? (grant_i & AUTO_MASK) : '0;

  always_comb begin
    flag_d = wr_i ? wdata_i : flag_q;
    flag_d = flag_d & ~hw_clr;
    flag_d = flag_d | set_i;   // a fresh event is never lost
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign flag_o  = flag_q;
  assign en_o    = en_q;
  assign ready_o = flag_q & en_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 13,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = seen[N];
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned N = 13,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned STRIDE_LG = 3,
  parameter logic [N-1:0] AUTO_MASK = '0,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bnd_i,
  input  logic              bnd_next_multi_i,
  input  logic              reti_i,
  input  logic              gie_wr_i,
  input  logic              gie_wdata_i,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N-1:0]      grant_i,
  output logic              fire_o,
  output logic              gie_o,
  output logic              lag_o,
  output logic              insvc_o,
  output logic              vec_req_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [N-1:0]      ack_o
);
  logic  gie_q, lag_q, insvc_q;
  logic  clr_now, set_now, open;
  gate_e gate_st;
  logic              vreq_q;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic [N-1:0]      ack_q;

  assign clr_now = gie_wr_i & ~gie_wdata_i & gie_q;
  assign set_now = gie_wr_i & gie_wdata_i;

  always_comb begin
    if (lag_q | clr_now) gate_st = GATE_LAG;
    else if (gie_q)      gate_st = GATE_OPEN;
    else                 gate_st = GATE_SHUT;
  end

  always_comb begin
    case (gate_st)
      GATE_OPEN: open = 1'b1;
      GATE_LAG:  open = ~bnd_next_multi_i;
      default:   open = 1'b0;
    endcase
  end

  assign fire_o  = bnd_i & ~insvc_q & any_i & open;
  assign vaddr_d = ADDR_W'(VEC_BASE) + (ADDR_W'(idx_i) << STRIDE_LG);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      lag_q   <= 1'b0;
      insvc_q <= 1'b0;
      vreq_q  <= 1'b0;
      vaddr_q <= '0;
      ack_q   <= '0;
    end else begin
      if (gie_wr_i) gie_q <= gie_wdata_i;
      if (set_now || bnd_i) lag_q <= 1'b0;
      else if (clr_now)     lag_q <= 1'b1;
      if (fire_o)      insvc_q <= 1'b1;
      else if (reti_i) insvc_q <= 1'b0;
      vreq_q <= fire_o;
      if (fire_o) vaddr_q <= vaddr_d;
      ack_q <= fire_o ? (grant_i & AUTO_MASK) : '0;
    end
  end

  assign gie_o      = gie_q;
  assign lag_o      = lag_q;
  assign insvc_o    = insvc_q;
  assign vec_req_o  = vreq_q;
  assign vec_addr_o = vaddr_q;
  assign ack_o      = ack_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = N_SRC_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned VEC_BASE = VEC_BASE_DEF,
  parameter int unsigned STRIDE_LG = STRIDE_LG_DEF,
  parameter logic [N_SRC-1:0] AUTO_MASK = AUTO_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_set_i,
  input  logic              flag_wr_i,
  input  logic [N_SRC-1:0]  flag_wdata_i,
  input  logic              en_wr_i,
  input  logic [N_SRC-1:0]  en_wdata_i,
  input  logic              gie_wr_i,
  input  logic              gie_wdata_i,
  input  logic              bnd_i,
  input  logic              bnd_next_multi_i,
  input  logic              reti_i,
  output logic              vec_req_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [N_SRC-1:0]  ack_o,
  output logic [N_SRC-1:0]  flag_o,
  output logic [N_SRC-1:0]  en_o,
  output logic              gie_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] ready, grant;
  logic [IDX_W-1:0] idx;
  logic             any, fire, lag_q, insvc_q;

  irq_flag_bank #(.N(N_SRC), .AUTO_MASK(AUTO_MASK)) u_bank (
    .clk(clk), .rst(rst), .set_i(src_set_i),
    .wr_i(flag_wr_i), .wdata_i(flag_wdata_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .fire_i(fire), .grant_i(grant),
    .flag_o(flag_o), .en_o(en_o), .ready_o(ready)
  );

  irq_prio_pick #(.N(N_SRC)) u_pick (
    .req_i(ready), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  irq_seq #(
    .N(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
    .STRIDE_LG(STRIDE_LG), .AUTO_MASK(AUTO_MASK)
  ) u_seq (
    .clk(clk), .rst(rst), .bnd_i(bnd_i), .bnd_next_multi_i(bnd_next_multi_i),
    .reti_i(reti_i), .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i),
    .any_i(any), .idx_i(idx), .grant_i(grant), .fire_o(fire),
    .gie_o(gie_o), .lag_o(lag_q), .insvc_o(insvc_q),
    .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o), .ack_o(ack_o)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned N_SRC = 13,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bnd_i,
  input logic              vec_req_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [N_SRC-1:0]  ack_o,
  input logic [N_SRC-1:0]  flag_o,
  input logic              gie_o,
  input logic              lag_q,
  input logic              insvc_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (flag_o == '0 && !vec_req_o && !insvc_q && !gie_o && ack_o == '0));

  p_vec_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> $past(bnd_i));

  p_vec_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |=> !vec_req_o);

  p_vec_addr_slot_r4: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (vec_addr_o[2:0] == 3'd3));

  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));

  p_ack_with_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_o != '0) |-> vec_req_o);

  p_vec_needs_idle_r7: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (!$past(insvc_q) && insvc_q));

  p_vec_needs_gate_r9: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> $past(gie_o || lag_q));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bnd_i(bnd_i), .vec_req_o(vec_req_o),
  .vec_addr_o(vec_addr_o), .ack_o(ack_o), .flag_o(flag_o), .gie_o(gie_o),
  .lag_q(lag_q), .insvc_q(insvc_q)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_set = '0, flag_wdata = '0, en_wdata = '0;
  logic          flag_wr = 1'b0, en_wr = 1'b0, gie_wr = 1'b0, gie_wdata = 1'b0;
  logic          bnd = 1'b0, bnd_multi = 1'b0, reti = 1'b0;
  logic          vec_req, gie;
  logic [15:0]   vec_addr;
  logic [N-1:0]  ack, flag, en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .src_set_i(src_set), .flag_wr_i(flag_wr),
    .flag_wdata_i(flag_wdata), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .gie_wr_i(gie_wr), .gie_wdata_i(gie_wdata), .bnd_i(bnd),
    .bnd_next_multi_i(bnd_multi), .reti_i(reti), .vec_req_o(vec_req),
    .vec_addr_o(vec_addr), .ack_o(ack), .flag_o(flag), .en_o(en), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    src_set = '0; flag_wr = 0; en_wr = 0; gie_wr = 0; bnd = 0; reti = 0; bnd_multi = 0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse_set(input logic [N-1:0] v);
    @(negedge clk); src_set = v;
    @(negedge clk); src_set = '0;
  endtask

  task automatic wr_flag(input logic [N-1:0] v);
    @(negedge clk); flag_wr = 1; flag_wdata = v;
    @(negedge clk); flag_wr = 0;
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    @(negedge clk); en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic wr_gie(input logic v);
    @(negedge clk); gie_wr = 1; gie_wdata = v;
    @(negedge clk); gie_wr = 0;
  endtask

  // one boundary; on return the registered outcome of that boundary is visible
  task automatic boundary(input logic multi, input logic with_reti);
    @(negedge clk); bnd = 1; bnd_multi = multi; reti = with_reti;
    @(negedge clk); bnd = 0; bnd_multi = 0; reti = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(flag == '0 && en == '0 && !gie && !vec_req && ack == '0, "R1 during reset", {flag, en, gie, vec_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(flag == '0 && en == '0 && !gie && !vec_req, "R1 after reset", {flag, en, gie, vec_req}, 0);
  endtask

  task automatic t_flag_write();
    do_reset();
    pulse_set(13'h0020);
    chk(flag == 13'h0020, "R2 hw set", flag, 13'h0020);
    wr_flag(13'h0101);
    chk(flag == 13'h0101, "R2 sw load", flag, 13'h0101);
    @(negedge clk); flag_wr = 1; flag_wdata = '0; src_set = 13'h0004;
    @(negedge clk); flag_wr = 0; src_set = '0;
    chk(flag == 13'h0004, "R2 set beats write 0", flag, 13'h0004);
  endtask

  task automatic t_prio_autoclr_reti();
    do_reset();
    wr_en('1); wr_gie(1);
    pulse_set(13'h0240);  // sources 6 and 9
    repeat (3) @(negedge clk);
    chk(!vec_req, "R3 no vector without boundary", vec_req, 0);
    boundary(0, 0);
    chk(vec_req, "R3 vector after boundary", vec_req, 1);
    chk(vec_addr == 16'h0033, "R4 lowest index address", vec_addr, 16'h0033);
    chk(ack == 13'h0040, "R6 ack auto-clear source", ack, 13'h0040);
    chk(flag == 13'h0200, "R6 auto-cleared flag", flag, 13'h0200);
    boundary(0, 0);
    chk(!vec_req, "R7 blocked while in service", vec_req, 0);
    boundary(0, 1);
    chk(!vec_req, "R7 no vector on return boundary", vec_req, 0);
    boundary(0, 0);
    chk(vec_req && vec_addr == 16'h004B, "R7 re-entry next boundary", vec_addr, 16'h004B);
    chk(ack == '0 && flag == 13'h0200, "R6 non-auto source stays set", {ack, flag}, 13'h0200);
  endtask

  task automatic t_soft_set();
    do_reset();
    wr_en('1); wr_gie(1);
    wr_flag(13'h1000);
    boundary(1, 0);
    chk(vec_req && vec_addr == 16'h0063, "R5 software-set vectors", vec_addr, 16'h0063);
  endtask

  task automatic t_disabled();
    do_reset();
    wr_en(13'h1FFE); wr_gie(1);
    pulse_set(13'h0009);  // sources 0 and 3, source 0 disabled
    boundary(0, 0);
    chk(vec_req && vec_addr == 16'h001B, "R10 disabled source skipped", vec_addr, 16'h001B);
    chk(flag[0], "R10 disabled flag stays pending", flag, 13'h0001);
    do_reset();
    wr_en('1);
    pulse_set(13'h0002);
    boundary(0, 0);
    chk(!vec_req, "R9 no vector with global enable 0", vec_req, 0);
  endtask

  task automatic t_gie_lag();
    do_reset();
    wr_en('1); wr_gie(1); wr_gie(0);
    chk(!gie, "R8 global enable reads 0", gie, 0);
    pulse_set(13'h0010);
    boundary(0, 0);
    chk(vec_req && vec_addr == 16'h0023, "R8 single-cycle next still vectors", vec_addr, 16'h0023);
    chk(!gie, "R8 global enable 0 in handler", gie, 0);
    do_reset();
    wr_en('1); wr_gie(1); wr_gie(0);
    pulse_set(13'h0010);
    boundary(1, 0);
    chk(!vec_req, "R8 multi-cycle next blocks", vec_req, 0);
    boundary(0, 0);
    chk(!vec_req, "R9 later boundary blocked", vec_req, 0);
    chk(flag == 13'h0010, "R9 flag still pending", flag, 13'h0010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flag_write();
    t_prio_autoclr_reti();
    t_soft_set();
    t_disabled();
    t_gie_lag();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule